// File: doc/BRIEF.md
# Signal-Power Custom-Instruction Execution Unit

This block is an execution unit that hangs off the user-instruction port of a pipelined RISC core. In the execute stage it receives the full 32-bit instruction word, a valid flag, a start strobe and the two source operands. It decodes its own opcode and function fields. In that same cycle it reports whether the word is an encoding it does not own, and which general register the result must go to.

Each operand carries a 16-bit signed sample in its upper half. One operand is the real part of a complex sample and the other is the imaginary part. The unit computes:

- the squared magnitude of the sample;
- a halved magnitude, which cannot overflow;
- the square of the real part alone.

It can also load a 32-bit threshold into an internal register, and it can compare any of the three power values against that threshold to produce a 0/1 detection flag.

A parameter chooses between two timings. In the single-cycle form the result appears on the clock after start. In the registered form the unit holds the pipeline with a stall output while it works. A kill input cancels a registered operation whose result is no longer wanted.

Top module: `sqp_xu`

## Requirements
- R1: A word is owned only when bits 31:26 are 28, bits 5:4 are 2'b01 and bits 3:0 are in the range 0..6. `reserved` is 1, in the same cycle, exactly when `start` and `instr_vld` are both 1 and the word is not owned.
- R2: `dest_idx` is combinational. It equals instr[15:11] for owned function codes 0, 1, 2, 4, 5 and 6 while `instr_vld` is 1. It is 0 for function 3, for words that are not owned, and whenever `instr_vld` is 0.
- R3: Function 0 returns s(rs)² + s(rt)². Function 2 returns s(rs)². Here s(x) is x[31:16] read as a two's-complement value.
- R4: Function 1 returns (s(rs)² + s(rt)²) >> 1, taken over the full 32-bit sum.
- R5: Function 3 copies all 32 bits of rs into the threshold and leaves `result` unchanged.
- R6: Functions 4, 5 and 6 compute the values of functions 0, 1 and 2 respectively. Each returns 32'd1 when its value is strictly greater than the threshold, compared as unsigned, and 32'd0 otherwise.
- R7: With MULTI=0, a result-producing instruction accepted on a start edge appears on `result` on the next clock, and `stall` is always 0.
- R8: With MULTI=1 and HOLD_CYCLES=N, the sequence after an accepted result-producing start is as follows:
  - `stall` is 1 in clock cycles 1..N after the start edge and 0 in cycle N+1;
  - `result` changes only in cycle N+2;
  - `result` is stable while `stall` is 1;
  - a start in cycle N+1 is accepted;
  - function 3 never stalls.
- R9: With MULTI=1, `kill_m` and `run_m` both high while `stall` is 1 cancel the operation. `stall` is 0 from the next cycle, and `result` keeps its previous value.
- R10: A word that is not owned, or a start with `instr_vld` low, leaves both the threshold and `result` unchanged.
- R11: Synchronous reset clears the threshold, `result` and `stall` to 0. `present` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word in execute stage |
| instr_vld | input | 1 | Instruction word is valid |
| start | input | 1 | Execute-stage run strobe |
| opa | input | 32 | First source operand (rs) |
| opb | input | 32 | Second source operand (rt) |
| kill_m | input | 1 | Cancel request from the memory stage |
| run_m | input | 1 | Memory stage advancing; qualifies kill_m |
| reserved | output | 1 | Unowned encoding, valid with start |
| dest_idx | output | 5 | Destination register, 0 for no write |
| result | output | 32 | Memory-stage result |
| stall | output | 1 | Hold the pipeline, registered mode only |
| present | output | 1 | Constant 1 |

## Verification
Two pairs of functions can share a clock edge.

The first pair is a threshold load followed at once by a compare. In single-cycle mode the table walk issues these back to back with start held high. The bench then checks that the compare sees the new threshold, and that a compare issued just before a load sees the old one.

The second pair is publication of a registered result and acceptance of the next instruction. In registered mode a new start is driven in the cycle where stall has just fallen. The bench then checks two things: that the earlier value lands on `result` in that edge, and that the new operation raises stall and later publishes its own value.

// File: rtl/sqp_pkg.sv
package sqp_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned REG_W  = 5;

    localparam logic [5:0] MAJOR_OP  = 6'd28;
    localparam logic [1:0] SUB_CLASS = 2'b01;
    localparam logic [3:0] LAST_FN   = 4'd6;

    typedef enum logic [3:0] {
        FN_PWR      = 4'd0,
        FN_PWR_HALF = 4'd1,
        FN_RE       = 4'd2,
        FN_THR_LOAD = 4'd3,
        FN_CMP_PWR  = 4'd4,
        FN_CMP_HALF = 4'd5,
        FN_CMP_RE   = 4'd6
    } fn_e;

    typedef struct packed {
        logic              ours;
        logic              writes;
        fn_e               fn;
        logic [REG_W-1:0]  dest;
    } dec_t;

    typedef struct packed {
        fn_e                fn;
        logic [WORD_W-1:0]  a;
        logic [WORD_W-1:0]  b;
        logic [WORD_W-1:0]  thr;
    } job_t;

    function automatic dec_t decode_word(logic [WORD_W-1:0] ir, logic vld);
        dec_t d;
        d = '0;
        if (vld && ir[31:26] == MAJOR_OP && ir[5:4] == SUB_CLASS && ir[3:0] <= LAST_FN) begin
            d.ours   = 1'b1;
            d.fn     = fn_e'(ir[3:0]);
            d.writes = (ir[3:0] != FN_THR_LOAD);
            d.dest   = d.writes ? ir[15:11] : '0;
        end
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] finish_op(fn_e fn,
                                                    logic [WORD_W-1:0] sq_re,
                                                    logic [WORD_W-1:0] sq_im,
                                                    logic [WORD_W-1:0] thr);
        logic [WORD_W-1:0] sum;
        logic [WORD_W-1:0] val;
        logic              cmp;
        sum = sq_re + sq_im;
        cmp = 1'b0;
        case (fn)
            FN_PWR, FN_CMP_PWR:       val = sum;
            FN_PWR_HALF, FN_CMP_HALF: val = sum >> 1;
            FN_RE, FN_CMP_RE:         val = sq_re;
            default:                  val = '0;
        endcase
        case (fn)
            FN_CMP_PWR, FN_CMP_HALF, FN_CMP_RE: cmp = 1'b1;
            default:                            cmp = 1'b0;
        endcase
        if (cmp) begin
            return (val > thr) ? WORD_W'(1) : '0;
        end
        return val;
    endfunction

endpackage

// File: rtl/sqp_decode.sv
module sqp_decode
    import sqp_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    input  logic              vld,
    input  logic              start,
    output dec_t              dec,
    output logic              rsv
);
    always_comb begin
        dec = decode_word(ir, vld);
        rsv = start && vld && !dec.ours;
    end
endmodule

// File: rtl/sqp_square.sv
module sqp_square
    import sqp_pkg::*;
#(
    parameter int unsigned IN_W = WORD_W,
    parameter int unsigned SQ_W = WORD_W
) (
    input  logic [IN_W-1:0] word,
    output logic [SQ_W-1:0] sq
);
    localparam int unsigned H_W = IN_W / 2;

    logic signed [H_W-1:0]  half;
    logic signed [SQ_W-1:0] prod;

    always_comb begin
        half = word[IN_W-1:IN_W-H_W];
        prod = SQ_W'(half) * SQ_W'(half);
        sq   = prod;
    end
endmodule

// File: rtl/sqp_xu.sv
module sqp_xu
    import sqp_pkg::*;
#(
    parameter bit          MULTI       = 1'b0,
    parameter int unsigned HOLD_CYCLES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr,
    input  logic        instr_vld,
    input  logic        start,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic        kill_m,
    input  logic        run_m,
    output logic        reserved,
    output logic [4:0]  dest_idx,
    output logic [31:0] result,
    output logic        stall,
    output logic        present
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam int unsigned NSQ   = 2;

    dec_t              dec;
    logic              accept;
    logic              idle;
    logic [WORD_W-1:0] thr_q;
    logic [WORD_W-1:0] res_q;
    logic [WORD_W-1:0] sq_src [NSQ];
    logic [WORD_W-1:0] sq_val [NSQ];

    sqp_decode u_dec (
        .ir    (instr),
        .vld   (instr_vld),
        .start (start),
        .dec   (dec),
        .rsv   (reserved)
    );

    assign dest_idx = dec.dest;
    assign present  = 1'b1;
    assign accept   = start && dec.ours && idle;

    for (genvar g = 0; g < NSQ; g++) begin : g_sq
        sqp_square #(.IN_W(WORD_W), .SQ_W(WORD_W)) u_sq (
            .word (sq_src[g]),
            .sq   (sq_val[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (accept && dec.fn == FN_THR_LOAD) begin
            thr_q <= opa;
        end
    end

    if (!MULTI) begin : g_single
        assign idle      = 1'b1;
        assign stall     = 1'b0;
        assign sq_src[0] = opa;
        assign sq_src[1] = opb;

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
            end else if (accept && dec.writes) begin
                res_q <= finish_op(dec.fn, sq_val[0], sq_val[1], thr_q);
            end
        end
    end else begin : g_multi
        job_t              job_q;
        logic [WORD_W-1:0] sq_q [NSQ];
        logic [CNT_W-1:0]  cnt_q;
        logic              fin_q;
        logic              cancel;

        assign idle      = (cnt_q == '0);
        assign stall     = !idle;
        assign cancel    = !idle && kill_m && run_m;
        assign sq_src[0] = job_q.a;
        assign sq_src[1] = job_q.b;

        always_ff @(posedge clk) begin
            if (rst) begin
                job_q <= '0;
            end else if (accept && dec.writes) begin
                job_q.fn  <= dec.fn;
                job_q.a   <= opa;
                job_q.b   <= opb;
                job_q.thr <= thr_q;
            end
        end

        for (genvar g = 0; g < NSQ; g++) begin : g_sq_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    sq_q[g] <= '0;
                end else begin
                    sq_q[g] <= sq_val[g];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
                fin_q <= 1'b0;
            end else if (cancel) begin
                cnt_q <= '0;
                fin_q <= 1'b0;
            end else if (accept && dec.writes) begin
                cnt_q <= CNT_W'(HOLD_CYCLES);
                fin_q <= 1'b0;
            end else if (!idle) begin
                cnt_q <= cnt_q - 1'b1;
                fin_q <= (cnt_q == CNT_W'(1));
            end else begin
                fin_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
            end else if (fin_q) begin
                res_q <= finish_op(job_q.fn, sq_q[0], sq_q[1], job_q.thr);
            end
        end
    end

    assign result = res_q;

endmodule

// File: rtl/sqp_xu_chk.sv
module sqp_xu_chk #(
    parameter bit          MULTI       = 1'b0,
    parameter int unsigned HOLD_CYCLES = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        instr_vld,
    input logic        start,
    input logic        kill_m,
    input logic        run_m,
    input logic        reserved,
    input logic [4:0]  dest_idx,
    input logic [31:0] result,
    input logic        stall,
    input logic        present
);
    a_r1_reserved_needs_start: assert property (@(posedge clk) disable iff (rst)
        !start |-> !reserved);

    a_r2_reserved_no_dest: assert property (@(posedge clk) disable iff (rst)
        reserved |-> dest_idx == 5'd0);

    a_r2_invalid_no_dest: assert property (@(posedge clk) disable iff (rst)
        !instr_vld |-> dest_idx == 5'd0);

    a_r11_present_high: assert property (@(posedge clk) disable iff (rst)
        present);

    if (!MULTI) begin : g_single_chk
        a_r7_never_stall: assert property (@(posedge clk) disable iff (rst)
            !stall);
    end else begin : g_multi_chk
        a_r8_stall_after_start: assert property (@(posedge clk) disable iff (rst)
            start && !stall && dest_idx != 5'd0 |=> stall);

        a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
            stall |=> $stable(result));

        a_r9_kill_drops_stall: assert property (@(posedge clk) disable iff (rst)
            stall && kill_m && run_m |=> !stall);
    end
endmodule

bind sqp_xu sqp_xu_chk #(.MULTI(MULTI), .HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr_vld (instr_vld),
    .start     (start),
    .kill_m    (kill_m),
    .run_m     (run_m),
    .reserved  (reserved),
    .dest_idx  (dest_idx),
    .result    (result),
    .stall     (stall),
    .present   (present)
);

// File: tb/tb_sqp_xu.sv
module tb_sqp_xu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        instr_vld = 1'b0;
    logic        start = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        kill_m = 1'b0;
    logic        run_m = 1'b0;

    logic        rsv_s, stall_s, pres_s, rsv_m, stall_m, pres_m;
    logic [4:0]  dst_s, dst_m;
    logic [31:0] res_s, res_m;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] thr_m;
    logic [31:0] exp_r;
    logic [31:0] prev;

    always #5 clk = ~clk;

    sqp_xu #(.MULTI(1'b0), .HOLD_CYCLES(2)) dut (
        .clk(clk), .rst(rst), .instr(instr), .instr_vld(instr_vld), .start(start),
        .opa(opa), .opb(opb), .kill_m(kill_m), .run_m(run_m),
        .reserved(rsv_s), .dest_idx(dst_s), .result(res_s), .stall(stall_s), .present(pres_s));

    sqp_xu #(.MULTI(1'b1), .HOLD_CYCLES(2)) dut_mc (
        .clk(clk), .rst(rst), .instr(instr), .instr_vld(instr_vld), .start(start),
        .opa(opa), .opb(opb), .kill_m(kill_m), .run_m(run_m),
        .reserved(rsv_m), .dest_idx(dst_m), .result(res_m), .stall(stall_m), .present(pres_m));

    // stimulus table: {fn, rs, rt}
    localparam logic [67:0] VEC [12] = '{
        {4'd0, 32'h1234_0000, 32'h0567_ffff},
        {4'd1, 32'hffff_0000, 32'h7fff_0000},
        {4'd2, 32'h8000_0000, 32'h0000_0000},
        {4'd3, 32'h2000_0000, 32'h0000_0000},
        {4'd4, 32'h7fff_0000, 32'h0001_0000},
        {4'd5, 32'h0010_0000, 32'h0010_0000},
        {4'd6, 32'h8000_0000, 32'h0000_0000},
        {4'd3, 32'h4000_0000, 32'h0000_0000},
        {4'd6, 32'h8000_0000, 32'h0000_0000},
        {4'd0, 32'h8000_8000, 32'h8000_0000},
        {4'd4, 32'h8000_0000, 32'h8000_0000},
        {4'd2, 32'hc000_0000, 32'h0000_0000}
    };

    function automatic logic [31:0] model(logic [3:0] fn, logic [31:0] rs,
                                          logic [31:0] rt, logic [31:0] thr);
        longint a, b, p;
        a = longint'($signed(rs[31:16]));
        b = longint'($signed(rt[31:16]));
        case (fn)
            4'd0, 4'd4: p = a * a + b * b;
            4'd1, 4'd5: p = (a * a + b * b) / 2;
            default:    p = a * a;
        endcase
        if (fn >= 4'd4) return (p > longint'(thr)) ? 32'd1 : 32'd0;
        return 32'(p);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] rs, input logic [31:0] rt, input logic [4:0] rd);
        instr     = {op, 5'd1, 5'd2, rd, 5'd0, fn};
        instr_vld = 1'b1;
        start     = 1'b1;
        opa       = rs;
        opb       = rt;
    endtask

    task automatic idle();
        start     = 1'b0;
        instr_vld = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 result", res_s, 32'd0);
        chk("R11 stall", {31'd0, stall_m}, 32'd0);
        chk("R11 present", {31'd0, pres_s & pres_m}, 32'd1);
        issue(6'd28, 6'h16, 32'h0000_0000, 32'd0, 5'd3);
        @(negedge clk);
        chk("R6 strict vs zero threshold", res_s, 32'd0);
        issue(6'd28, 6'h16, 32'h0001_0000, 32'd0, 5'd3);
        @(negedge clk);
        chk("R11 threshold cleared", res_s, 32'd1);
        idle();

        // table walk, start held high back to back (R1..R7)
        do_reset();
        thr_m = '0;
        exp_r = '0;
        for (int i = 0; i < 12; i++) begin
            logic [3:0] f;
            logic [4:0] rd;
            f  = VEC[i][67:64];
            rd = 5'(i + 1);
            if (i > 0) chk("R7 single-cycle result", res_s, exp_r);
            issue(6'd28, {2'b01, f}, VEC[i][63:32], VEC[i][31:0], rd);
            #1;
            chk("R1 owned not reserved", {31'd0, rsv_s}, 32'd0);
            chk("R2 dest index", {27'd0, dst_s}, (f == 4'd3) ? 32'd0 : {27'd0, rd});
            if (f != 4'd3) exp_r = model(f, VEC[i][63:32], VEC[i][31:0], thr_m);
            else thr_m = VEC[i][63:32];
            @(negedge clk);
        end
        chk("R7 last result", res_s, exp_r);
        chk("R7 no stall", {31'd0, stall_s}, 32'd0);
        idle();

        // hand-worked values R3 R4
        issue(6'd28, 6'h10, 32'h8000_0000, 32'hbeaf_0000, 5'd10);
        @(negedge clk);
        chk("R3 fn0", res_s, 32'h50AA_3BA1);
        issue(6'd28, 6'h11, 32'h8000_0000, 32'hbeaf_0000, 5'd10);
        @(negedge clk);
        chk("R4 fn1", res_s, 32'h2855_1DD0);
        issue(6'd28, 6'h12, 32'h8000_0000, 32'hbeaf_0000, 5'd10);
        @(negedge clk);
        chk("R3 fn2", res_s, 32'h4000_0000);
        // R5 load leaves result
        issue(6'd28, 6'h13, 32'h7fff_ffff, 32'd0, 5'd9);
        #1;
        chk("R2 load has no dest", {27'd0, dst_s}, 32'd0);
        @(negedge clk);
        chk("R5 result unchanged by load", res_s, 32'h4000_0000);
        // R6 unsigned: 0x80000000 > 0x7fffffff
        issue(6'd28, 6'h14, 32'h8000_0000, 32'h8000_0000, 5'd4);
        @(negedge clk);
        chk("R6 unsigned compare", res_s, 32'd1);
        // R10 unowned opcode with load function and rs=0
        issue(6'd29, 6'h13, 32'h0000_0000, 32'd0, 5'd7);
        #1;
        chk("R1 wrong opcode reserved", {31'd0, rsv_s}, 32'd1);
        chk("R10 reserved dest zero", {27'd0, dst_s}, 32'd0);
        @(negedge clk);
        chk("R10 result unchanged", res_s, 32'd1);
        issue(6'd28, 6'h07, 32'h0000_0000, 32'd0, 5'd7);
        #1;
        chk("R1 fn7 reserved", {31'd0, rsv_s}, 32'd1);
        @(negedge clk);
        issue(6'd28, 6'h03, 32'h0000_0000, 32'd0, 5'd7);
        #1;
        chk("R1 wrong subclass reserved", {31'd0, rsv_s}, 32'd1);
        @(negedge clk);
        issue(6'd28, 6'h13, 32'h0000_0000, 32'd0, 5'd7);
        instr_vld = 1'b0;
        #1;
        chk("R1 invalid not reserved", {31'd0, rsv_s}, 32'd0);
        @(negedge clk);
        issue(6'd28, 6'h16, 32'h0001_0000, 32'd0, 5'd5);
        @(negedge clk);
        chk("R10 threshold unchanged", res_s, 32'd0);
        idle();

        // registered mode R8
        do_reset();
        issue(6'd28, 6'h10, 32'h8000_0000, 32'hbeaf_0000, 5'd10);
        @(negedge clk);
        idle();
        chk("R8 stall cycle1", {31'd0, stall_m}, 32'd1);
        @(negedge clk);
        chk("R8 stall cycle2", {31'd0, stall_m}, 32'd1);
        chk("R8 result held", res_m, 32'd0);
        @(negedge clk);
        chk("R8 stall drops", {31'd0, stall_m}, 32'd0);
        chk("R8 result not yet", res_m, 32'd0);
        // start in the drop cycle
        issue(6'd28, 6'h12, 32'hc000_0000, 32'd0, 5'd11);
        @(negedge clk);
        idle();
        chk("R8 result published", res_m, 32'h50AA_3BA1);
        chk("R8 overlapped start stalls", {31'd0, stall_m}, 32'd1);
        repeat (2) @(negedge clk);
        chk("R8 second stall drops", {31'd0, stall_m}, 32'd0);
        @(negedge clk);
        chk("R8 second result", res_m, 32'h1000_0000);
        // load never stalls
        issue(6'd28, 6'h13, 32'h0fff_ffff, 32'd0, 5'd0);
        @(negedge clk);
        idle();
        chk("R8 load no stall", {31'd0, stall_m}, 32'd0);
        issue(6'd28, 6'h16, 32'h8000_0000, 32'd0, 5'd2);
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        chk("R6 registered compare", res_m, 32'd1);

        // R9 kill
        prev = res_m;
        issue(6'd28, 6'h12, 32'h0002_0000, 32'd0, 5'd6);
        @(negedge clk);
        idle();
        kill_m = 1'b1;
        run_m  = 1'b0;
        @(negedge clk);
        chk("R9 kill needs run", {31'd0, stall_m}, 32'd1);
        run_m = 1'b1;
        @(negedge clk);
        kill_m = 1'b0;
        run_m  = 1'b0;
        chk("R9 kill drops stall", {31'd0, stall_m}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R9 result kept", res_m, prev);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule